// File: doc/BRIEF.md
# Window-Fetch FIFO Buffer

This block feeds a pipelined three-input datapath that computes one result per iteration from elements i, i+1 and i+2 of an array in memory. For every iteration it issues three read requests, one per window element, even when the previous window already fetched two of them. It gathers the returned words into one packed window and queues finished windows in a FIFO, which hands them to the datapath through a valid/ready handshake.

A start pulse with an iteration count launches a run. The request side reserves a FIFO slot before it issues the first read of a window, so reads pause while the FIFO and the windows still in flight fill every slot. When no window is ready, the block either presents an empty cycle (bubble mode) or raises a stall line that holds the downstream pipeline (stall mode). Stall mode is the one to use when the pipeline has feedback. A done flag marks the hand-over of the last window.

Top module: `win_fifo_buf`

## Requirements
- R1: The window for iteration i carries the memory words at addresses i, i+1 and i+2. Each word is 32 bits, and the word at address i sits in bits [31:0], i+1 in [63:32] and i+2 in [95:64].
- R2: Exactly N windows are delivered, in iteration order 0..N-1. No window is valid once done is set.
- R3: Each iteration issues exactly three reads, in the address order i, i+1, i+2, so a run of N iterations makes 3N reads and then issues no more.
- R4: A new window's first read is issued only while fewer than DEPTH windows are reserved (in flight or queued and not yet taken). The FIFO never overflows or underflows.
- R5: A read request that is not accepted (ready low) stays asserted with the same address in the next cycle.
- R6: A valid window that is not taken (ready low) stays valid with unchanged data in the next cycle.
- R7: In bubble mode (stall_mode_i = 0) the stall output is always low, and a starved cycle shows valid low.
- R8: In stall mode (stall_mode_i = 1), a cycle during a run with no window available raises the stall output. The stall output is low whenever no run is active.
- R9: Done rises in the cycle after the Nth window is taken, stays low during a run, and is cleared by the next accepted start. A start pulse during a run is ignored.
- R10: After reset there is no read request, no valid window, no stall and no done.
- R11: A start with N = 0 sets done in the next cycle and issues no reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for a run |
| iter_cnt_i | input | CNT_W | Iteration count N, sampled on an accepted start |
| stall_mode_i | input | 1 | 1: stall when starved, 0: insert bubble |
| mem_req_o | output | 1 | Read request valid |
| mem_addr_o | output | ADDR_W | Read element address |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rsp_valid_i | input | 1 | Read data returned (in request order) |
| mem_rsp_data_i | input | ELEM_W | Returned element |
| win_valid_o | output | 1 | A complete window is presented |
| win_data_o | output | WIN_LEN*ELEM_W | Packed window, lowest index in the LSBs |
| win_ready_i | input | 1 | Datapath takes the window |
| dp_stall_o | output | 1 | Hold the downstream pipeline (stall mode) |
| done_o | output | 1 | The run has delivered its last window |

## Verification
The sweep runs both empty-cycle modes with iteration counts 1, 2, 5 and 7 under three input patterns. An always-ready memory with single-cycle latency and an always-ready datapath checks the basic packing and ordering. A memory with random acceptance and latency separates in-order window assembly from timing luck, and it starves the output so that the bubble and stall behaviour can be told apart. A datapath that refuses windows at first fills the FIFO, which exposes how the reservation count throttles reads and whether the output holds under backpressure. Additional runs check a zero-length start and a start pulse that arrives during an active run.

// File: rtl/wfb_pkg.sv
package wfb_pkg;
  localparam int unsigned ELEM_W_D  = 32;
  localparam int unsigned WIN_LEN_D = 3;
  localparam int unsigned DEPTH_D   = 4;
  localparam int unsigned CNT_W_D   = 16;
  localparam int unsigned ADDR_W_D  = 16;
endpackage

// File: rtl/wfb_req_gen.sv
module wfb_req_gen #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned WIN_LEN = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  iter_cnt_i,
  input  logic              mem_ready_i,
  input  logic              pop_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o
);
  localparam int unsigned KW  = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
  localparam int unsigned CRW = $clog2(DEPTH + 1);

  logic             active_q;
  logic [CNT_W-1:0] win_idx_q, last_idx_q;
  logic [KW-1:0]    elem_q;
  logic [CRW-1:0]   credit_q;
  logic             acc, first_acc;

  // a window's first read reserves a FIFO slot
  assign mem_req_o  = active_q && ((elem_q != '0) || (credit_q < CRW'(DEPTH)));
  assign mem_addr_o = ADDR_W'(win_idx_q) + ADDR_W'(elem_q);
  assign acc        = mem_req_o && mem_ready_i;
  assign first_acc  = acc && (elem_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      win_idx_q  <= '0;
      last_idx_q <= '0;
      elem_q     <= '0;
    end else if (start_i) begin
      active_q   <= (iter_cnt_i != '0);
      win_idx_q  <= '0;
      last_idx_q <= iter_cnt_i - CNT_W'(1);
      elem_q     <= '0;
    end else if (acc) begin
      if (elem_q == KW'(WIN_LEN - 1)) begin
        elem_q <= '0;
        if (win_idx_q == last_idx_q) active_q <= 1'b0;
        else win_idx_q <= win_idx_q + CNT_W'(1);
      end else begin
        elem_q <= elem_q + KW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) credit_q <= '0;
    else credit_q <= credit_q + CRW'(first_acc) - CRW'(pop_i);
  end

  assert_credit_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    credit_q <= CRW'(DEPTH));
  assert_req_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i && !start_i) |=> (mem_req_o && $stable(mem_addr_o)));
endmodule

// File: rtl/wfb_win_asm.sv
module wfb_win_asm #(
  parameter int unsigned ELEM_W  = 32,
  parameter int unsigned WIN_LEN = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rsp_valid_i,
  input  logic [ELEM_W-1:0]         rsp_data_i,
  output logic                      push_o,
  output logic [WIN_LEN*ELEM_W-1:0] win_o
);
  localparam int unsigned KW = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;

  logic [KW-1:0]     slot_q;
  logic [ELEM_W-1:0] part_q [WIN_LEN-1];

  assign push_o = rsp_valid_i && (slot_q == KW'(WIN_LEN - 1));

  for (genvar j = 0; j < WIN_LEN - 1; j++) begin : g_pack
    assign win_o[j*ELEM_W +: ELEM_W] = part_q[j];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) part_q[j] <= '0;
      else if (rsp_valid_i && slot_q == KW'(j)) part_q[j] <= rsp_data_i;
    end
  end
  assign win_o[(WIN_LEN-1)*ELEM_W +: ELEM_W] = rsp_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else if (rsp_valid_i) slot_q <= push_o ? '0 : slot_q + KW'(1);
  end
endmodule

// File: rtl/wfb_fifo.sv
module wfb_fifo #(
  parameter int unsigned WIDTH = 96,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign dout_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) if (push_i) mem_q[wr_q] <= din_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
      if (pop_i)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/win_fifo_buf.sv
module win_fifo_buf
  import wfb_pkg::*;
#(
  parameter int unsigned ELEM_W  = ELEM_W_D,
  parameter int unsigned WIN_LEN = WIN_LEN_D,
  parameter int unsigned DEPTH   = DEPTH_D,
  parameter int unsigned CNT_W   = CNT_W_D,
  parameter int unsigned ADDR_W  = ADDR_W_D,
  localparam int unsigned WIN_W  = WIN_LEN * ELEM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  iter_cnt_i,
  input  logic              stall_mode_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ready_i,
  input  logic              mem_rsp_valid_i,
  input  logic [ELEM_W-1:0] mem_rsp_data_i,
  output logic              win_valid_o,
  output logic [WIN_W-1:0]  win_data_o,
  input  logic              win_ready_i,
  output logic              dp_stall_o,
  output logic              done_o
);
  logic             busy_q, done_q;
  logic [CNT_W-1:0] n_q, deliv_q;
  logic             start_ok, pop, push, empty, full;
  logic [WIN_W-1:0] asm_win;

  assign start_ok    = start_i && !busy_q;
  assign pop         = win_valid_o && win_ready_i;
  assign win_valid_o = !empty;
  assign dp_stall_o  = stall_mode_i && busy_q && empty;
  assign done_o      = done_q;

  wfb_req_gen #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .WIN_LEN(WIN_LEN)) i_req (
    .clk_i, .rst_ni, .start_i(start_ok), .iter_cnt_i, .mem_ready_i,
    .pop_i(pop), .mem_req_o, .mem_addr_o
  );

  wfb_win_asm #(.ELEM_W(ELEM_W), .WIN_LEN(WIN_LEN)) i_asm (
    .clk_i, .rst_ni, .rsp_valid_i(mem_rsp_valid_i), .rsp_data_i(mem_rsp_data_i),
    .push_o(push), .win_o(asm_win)
  );

  wfb_fifo #(.WIDTH(WIN_W), .DEPTH(DEPTH)) i_fifo (
    .clk_i, .rst_ni, .push_i(push), .din_i(asm_win), .pop_i(pop),
    .dout_o(win_data_o), .empty_o(empty), .full_o(full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      n_q     <= '0;
      deliv_q <= '0;
    end else if (start_ok) begin
      busy_q  <= (iter_cnt_i != '0);
      done_q  <= (iter_cnt_i == '0);
      n_q     <= iter_cnt_i;
      deliv_q <= '0;
    end else if (pop) begin
      deliv_q <= deliv_q + CNT_W'(1);
      if (deliv_q == n_q - CNT_W'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assert_out_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_valid_o && !win_ready_i) |=> (win_valid_o && $stable(win_data_o)));
  assert_no_win_after_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !win_valid_o);
  assert_no_req_after_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);
  assert_bubble_no_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_mode_i && !win_valid_o) |-> !dp_stall_o);
  assert_full_is_bounded_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |-> !(push && !pop));
endmodule

// File: tb/test_win_fifo_buf.sv
module test_win_fifo_buf;
  localparam int DEPTH = 4;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        start_i = 1'b0, stall_mode_i = 1'b0;
  logic [15:0] iter_cnt_i = '0;
  logic        mem_req_o, mem_ready_i = 1'b0, mem_rsp_valid_i = 1'b0;
  logic [15:0] mem_addr_o;
  logic [31:0] mem_rsp_data_i = '0;
  logic        win_valid_o, win_ready_i = 1'b0, dp_stall_o, done_o;
  logic [95:0] win_data_o;

  always #5 clk = ~clk;

  win_fifo_buf #(.DEPTH(DEPTH)) i_win_fifo_buf (
    .clk_i(clk), .rst_ni, .start_i, .iter_cnt_i, .stall_mode_i,
    .mem_req_o, .mem_addr_o, .mem_ready_i, .mem_rsp_valid_i, .mem_rsp_data_i,
    .win_valid_o, .win_data_o, .win_ready_i, .dp_stall_o, .done_o
  );

  int checks = 0, fails = 0, cyc = 0, rc = 0;
  int mem_pat = 0, ds_pat = 0, run_n = 0;
  int reads = 0, started = 0, delivered = 0;
  int q_addr [64];
  int q_due  [64];
  int head = 0, tail = 0;
  bit start_req = 0, arm = 0, busy = 0, run_done = 0, agent_on = 0;
  logic [15:0] start_cnt = '0;

  function automatic logic [31:0] elem(input int a);
    logic [31:0] v = 32'(a);
    return (v * 32'h9E3779B1) ^ 32'hA5C30000;
  endfunction

  function automatic logic [95:0] exp_win(input int w);
    return {elem(w + 2), elem(w + 1), elem(w)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_all();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // memory, datapath and start driver
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      rc++;
      if (cyc > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        finish_all();
      end
      if (arm) begin
        busy = busy || (start_cnt != 0);
        arm = 0;
      end
      if (start_req) begin
        start_i = 1'b1; iter_cnt_i = start_cnt; start_req = 0; arm = 1; rc = 0;
      end else begin
        start_i = 1'b0;
      end
      if (head != tail && q_due[head % 64] <= cyc) begin
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = elem(q_addr[head % 64]);
        head++;
      end else begin
        mem_rsp_valid_i = 1'b0;
      end
      mem_ready_i = (mem_pat == 0) ? 1'b1 : 1'($urandom_range(0, 1));
      case (ds_pat)
        0: win_ready_i = 1'b1;
        1: win_ready_i = 1'($urandom_range(0, 1));
        default: win_ready_i = (rc > 20) ? 1'($urandom_range(0, 1)) : 1'b0;
      endcase
      #1;
      if (agent_on) begin
        if (mem_req_o && mem_ready_i) begin
          chk(mem_addr_o == 16'(reads / 3 + reads % 3), "R3 read address",
              96'(mem_addr_o), 96'(reads / 3 + reads % 3));
          if (reads % 3 == 0) begin
            started++;
            chk(started - delivered <= DEPTH, "R4 reserved windows",
                96'(started - delivered), 96'(DEPTH));
          end
          q_addr[tail % 64] = int'(mem_addr_o);
          q_due[tail % 64]  = cyc + ((mem_pat == 0) ? 1 : $urandom_range(1, 6));
          tail++;
          reads++;
        end
        if (busy) chk(!done_o, "R9 done low during run", 96'(done_o), 96'(0));
        if (busy && !win_valid_o)
          chk(dp_stall_o == stall_mode_i, "R7 R8 starved cycle stall",
              96'(dp_stall_o), 96'(stall_mode_i));
        if (!busy) chk(!dp_stall_o, "R8 stall low when idle", 96'(dp_stall_o), 96'(0));
        if (win_valid_o && win_ready_i) begin
          chk(win_data_o == exp_win(delivered), "R1 R2 window data", win_data_o, exp_win(delivered));
          delivered++;
          if (delivered == run_n) begin
            busy = 0; run_done = 1;
          end
        end
      end
    end
  end

  task automatic run_case(input bit mode, input int n, input int mp, input int dp, input bit restart);
    int t = 0;
    @(posedge clk);
    stall_mode_i = mode; mem_pat = mp; ds_pat = dp; run_n = n;
    reads = 0; started = 0; delivered = 0; run_done = 0;
    start_cnt = 16'(n); start_req = 1;
    while (!run_done && t < 3000) begin
      @(posedge clk);
      t++;
      if (restart && t == 10) begin
        start_cnt = 16'(9); start_req = 1;   // ignored: run still active
      end
    end
    repeat (6) @(posedge clk);
    @(negedge clk); #2;
    chk(run_done, "R2 all windows delivered", 96'(delivered), 96'(n));
    chk(done_o, "R9 done after last window", 96'(done_o), 96'(1));
    chk(reads == 3 * n, "R3 total reads", 96'(reads), 96'(3 * n));
    chk(!win_valid_o && !mem_req_o, "R2 R3 quiet after done",
        96'({win_valid_o, mem_req_o}), 96'(0));
    chk(!dp_stall_o, "R8 stall low after run", 96'(dp_stall_o), 96'(0));
  endtask

  initial begin
    stall_mode_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #2;
    chk({mem_req_o, win_valid_o, dp_stall_o, done_o} == 4'b0, "R10 reset state",
        96'({mem_req_o, win_valid_o, dp_stall_o, done_o}), 96'(0));
    agent_on = 1;
    // R11: zero-length run
    @(posedge clk);
    run_n = 0; reads = 0; start_cnt = 16'(0); start_req = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    chk(done_o, "R11 done on zero count", 96'(done_o), 96'(1));
    chk(reads == 0, "R11 no reads on zero count", 96'(reads), 96'(0));
    for (int m = 0; m < 2; m++)
      for (int ni = 0; ni < 4; ni++)
        for (int mp = 0; mp < 2; mp++)
          for (int dp = 0; dp < 3; dp++)
            run_case(1'(m), (ni == 0) ? 1 : (ni == 1) ? 2 : (ni == 2) ? 5 : 7, mp, dp, 1'b0);
    // R9: start pulse during an active run is ignored
    run_case(1'b1, 5, 1, 2, 1'b1);
    run_case(1'b0, 7, 1, 2, 1'b1);
    finish_all();
  end
endmodule